// File: doc/BRIEF.md
# Link-Layer Block Frame Receiver

This block sits after the answer-to-reset phase of a smart-card style serial link and turns the incoming character stream into checked link-layer frames. Each frame carries an address byte, a control byte, a length byte, as many payload bytes as the length byte states, and a closing check byte. The check byte makes the exclusive-OR of the whole frame zero. When the inverse signalling convention is in force, the block mirrors the bit order of every character before it looks at it.

The receiver hunts for a plausible address byte and drops anything else. It then walks through the control, length and payload fields. When the check byte arrives it gives its verdict. A good frame produces a one-cycle acceptance pulse carrying the frame class, the send and receive sequence numbers, and the length. The stored payload is then replayed as a stream of bytes with start and end markers. A bad frame produces a one-cycle error pulse and nothing else. A timeout strobe from the character timer throws away any partial frame.

Top module: `lfr_frame_rx`

## Requirements
- R1: After reset, frm_ok, frm_err, out_valid, out_sop and out_eop are low and frm_kind, frm_ns, frm_nr and frm_len are zero.
- R2: In the address-search state, a byte is taken as an address only when its high nibble is 1 or its low nibble is 1. Any other byte is discarded and the search goes on.
- R3: A frame is accepted only when the exclusive-OR of the address, control, length, all payload bytes and the check byte is zero. Acceptance is a one-cycle frm_ok pulse in the cycle after the clock edge that samples the check byte, with frm_len equal to the length byte.
- R4: A frame whose exclusive-OR is non-zero gives a one-cycle frm_err pulse at the same point in time, no frm_ok and no payload output. frm_ok and frm_err are never high together.
- R5: A control byte with bits 4 and 0 both clear is an information frame: frm_kind = 0, frm_ns = control bits 3:1, frm_nr = control bits 7:5.
- R6: Otherwise, a control byte whose low five bits equal 5'b01001 is a reject frame: frm_kind = 1, frm_nr = control bits 7:5, frm_ns = 0.
- R7: Otherwise, control 8'hEF is a resynchronisation frame (frm_kind = 2). Every other control value is unknown (frm_kind = 3). Both report frm_ns = frm_nr = 0.
- R8: While inverse_en is high, each input byte is bit-reversed (bit 7 swaps with bit 0, and so on) before any other use, including address checking and the checksum.
- R9: A timeout pulse returns the receiver to address search in the next cycle and drops any partial frame.
- R10: A length byte of 0 is legal. The next byte is the check byte, and an accepted empty frame produces no payload output.
- R11: An accepted frame with non-zero length replays its payload in order, one byte per cycle, starting in the same cycle as frm_ok. out_sop marks the first byte, out_eop marks the last, and out_valid stays high without a gap in between.
- R12: A length byte greater than MAX_LEN makes the frame fail with frm_err even when its checksum is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received character is present on in_byte |
| in_byte | input | 8 | Received character as it came off the line |
| inverse_en | input | 1 | Inverse convention active: mirror bit order |
| timeout | input | 1 | Character timer expired; abandon partial frame |
| frm_ok | output | 1 | One-cycle pulse: frame accepted |
| frm_err | output | 1 | One-cycle pulse: frame rejected |
| frm_kind | output | 2 | 0 information, 1 reject, 2 resync, 3 unknown |
| frm_ns | output | 3 | Send sequence number of an information frame |
| frm_nr | output | 3 | Receive sequence number (information or reject) |
| frm_len | output | 8 | Length of the accepted frame |
| out_valid | output | 1 | Replayed payload byte present |
| out_data | output | 8 | Replayed payload byte |
| out_sop | output | 1 | First payload byte of a frame |
| out_eop | output | 1 | Last payload byte of a frame |

## Verification
The bench builds the receiver with MAX_LEN = 16 rather than the default 255. A frame that fills the buffer exactly, one that runs one byte past it, and the length-limit rejection all become short sequences at that size. The replay store stays small while the full 8-bit length field is still exercised. The stimulus covers every control class, both bit-order conventions, an empty frame, address hunting through garbage, and a timeout in the middle of a frame.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    typedef enum logic [1:0] {
        ST_ADDR = 2'd0,
        ST_CTRL = 2'd1,
        ST_LEN  = 2'd2,
        ST_BODY = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        FK_INFO = 2'd0,
        FK_REJ  = 2'd1,
        FK_RES  = 2'd2,
        FK_UNK  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        rx_state_e   st;
        logic [7:0]  ctrl;
        logic [7:0]  len;
        logic [7:0]  cnt;
        logic [7:0]  sum;
        logic        ok;
        logic        err;
        frame_kind_e kind;
        logic [2:0]  ns;
        logic [2:0]  nr;
        logic [7:0]  olen;
    } parse_state_t;

    typedef struct packed {
        logic       active;
        logic [7:0] idx;
        logic [7:0] last;
    } replay_state_t;

endpackage

// File: rtl/lfr_bitrev.sv
module lfr_bitrev #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/lfr_ctrl_decode.sv
module lfr_ctrl_decode
    import lfr_pkg::*;
(
    input  logic [7:0]  ctrl,
    output frame_kind_e kind,
    output logic [2:0]  ns,
    output logic [2:0]  nr
);
    always_comb begin
        kind = FK_UNK;
        ns   = 3'd0;
        nr   = 3'd0;
        if ((ctrl & 8'h11) == 8'h00) begin
            kind = FK_INFO;
            ns   = ctrl[3:1];
            nr   = ctrl[7:5];
        end else if ((ctrl & 8'h1F) == 8'h09) begin
            kind = FK_REJ;
            nr   = ctrl[7:5];
        end else if (ctrl == 8'hEF) begin
            kind = FK_RES;
        end
    end
endmodule

// File: rtl/lfr_replay_buf.sv
module lfr_replay_buf
    import lfr_pkg::*;
#(
    parameter int MAX_LEN = 255,
    localparam int IDX_W  = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN),
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             start,
    input  logic [7:0]       start_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop
);
    logic [7:0]    mem [DEPTH];
    replay_state_t rp_d, rp_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_comb begin
        rp_d = rp_q;
        if (start && start_len != 8'd0) begin
            rp_d.active = 1'b1;
            rp_d.idx    = 8'd0;
            rp_d.last   = start_len - 8'd1;
        end else if (rp_q.active) begin
            if (rp_q.idx == rp_q.last) rp_d.active = 1'b0;
            else                       rp_d.idx    = rp_q.idx + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign out_valid = rp_q.active;
    assign out_data  = rp_q.active ? mem[rp_q.idx[IDX_W-1:0]] : 8'd0;
    assign out_sop   = rp_q.active && (rp_q.idx == 8'd0);
    assign out_eop   = rp_q.active && (rp_q.idx == rp_q.last);

    // R11
    replay_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> out_valid);
endmodule

// File: rtl/lfr_frame_rx.sv
module lfr_frame_rx
    import lfr_pkg::*;
#(
    parameter int MAX_LEN = 255,
    localparam int IDX_W  = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN),
    localparam logic [8:0] LIM = 9'(MAX_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       inverse_en,
    input  logic       timeout,
    output logic       frm_ok,
    output logic       frm_err,
    output logic [1:0] frm_kind,
    output logic [2:0] frm_ns,
    output logic [2:0] frm_nr,
    output logic [7:0] frm_len,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sop,
    output logic       out_eop
);
    parse_state_t     ps_d, ps_q;
    logic [7:0]       mirrored;
    logic [7:0]       b;
    frame_kind_e      dec_kind;
    logic [2:0]       dec_ns, dec_nr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             start;

    lfr_bitrev #(.W(8)) u_rev (.din(in_byte), .dout(mirrored));
    assign b = inverse_en ? mirrored : in_byte;

    lfr_ctrl_decode u_dec (
        .ctrl(ps_q.ctrl), .kind(dec_kind), .ns(dec_ns), .nr(dec_nr)
    );

    always_comb begin
        ps_d     = ps_q;
        ps_d.ok  = 1'b0;
        ps_d.err = 1'b0;
        wr_en    = 1'b0;
        wr_idx   = ps_q.cnt[IDX_W-1:0];
        start    = 1'b0;
        if (timeout) begin
            ps_d.st = ST_ADDR;
        end else if (in_valid) begin
            unique case (ps_q.st)
                ST_ADDR: begin
                    if (b[7:4] == 4'd1 || b[3:0] == 4'd1) begin
                        ps_d.sum = b;
                        ps_d.st  = ST_CTRL;
                    end
                end
                ST_CTRL: begin
                    ps_d.ctrl = b;
                    ps_d.sum  = ps_q.sum ^ b;
                    ps_d.st   = ST_LEN;
                end
                ST_LEN: begin
                    ps_d.len = b;
                    ps_d.cnt = 8'd0;
                    ps_d.sum = ps_q.sum ^ b;
                    ps_d.st  = ST_BODY;
                end
                ST_BODY: begin
                    if (ps_q.cnt != ps_q.len) begin
                        wr_en    = ({1'b0, ps_q.cnt} < LIM);
                        ps_d.cnt = ps_q.cnt + 8'd1;
                        ps_d.sum = ps_q.sum ^ b;
                    end else begin
                        ps_d.st = ST_ADDR;
                        if ((ps_q.sum ^ b) == 8'd0 && {1'b0, ps_q.len} <= LIM) begin
                            ps_d.ok   = 1'b1;
                            ps_d.kind = dec_kind;
                            ps_d.ns   = dec_ns;
                            ps_d.nr   = dec_nr;
                            ps_d.olen = ps_q.len;
                            start     = 1'b1;
                        end else begin
                            ps_d.err = 1'b1;
                        end
                    end
                end
                default: ps_d.st = ST_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    lfr_replay_buf #(.MAX_LEN(MAX_LEN)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(b),
        .start(start), .start_len(ps_q.len),
        .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    assign frm_ok   = ps_q.ok;
    assign frm_err  = ps_q.err;
    assign frm_kind = ps_q.kind;
    assign frm_ns   = ps_q.ns;
    assign frm_nr   = ps_q.nr;
    assign frm_len  = ps_q.olen;

    // R9
    timeout_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (ps_q.st == ST_ADDR));
    // R4
    ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ok && frm_err));
    // R11
    replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> frm_ok);
    // R10
    empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok && frm_len == 8'd0) |-> !out_valid);
    // R11
    replay_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok |-> $past(!out_valid || out_eop));
endmodule

// File: tb/lfr_frame_rx_tb.sv
module lfr_frame_rx_tb;
    localparam int MAXL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic       inverse_en = 1'b0;
    logic       timeout = 1'b0;
    logic       frm_ok, frm_err, out_valid, out_sop, out_eop;
    logic [1:0] frm_kind;
    logic [2:0] frm_ns, frm_nr;
    logic [7:0] frm_len, out_data;

    always #4 clk = ~clk;

    lfr_frame_rx #(.MAX_LEN(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .inverse_en(inverse_en), .timeout(timeout),
        .frm_ok(frm_ok), .frm_err(frm_err), .frm_kind(frm_kind),
        .frm_ns(frm_ns), .frm_nr(frm_nr), .frm_len(frm_len),
        .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    int n_chk = 0, n_fail = 0;
    int n_ok = 0, n_err = 0, n_eop = 0, rx_n = 0;
    logic [1:0] l_kind;
    logic [2:0] l_ns, l_nr;
    logic [7:0] l_len;
    logic [7:0] rx [256];

    // {ctrl, len, seed, addr, bad, inv, kind, ns, nr, exp_ok, pad}
    localparam logic [47:0] VEC [8] = '{
        {8'hA4, 8'd5,  8'd11, 8'h12, 1'b0, 1'b0, 2'd0, 3'd2, 3'd5, 1'b1, 5'd0},
        {8'h69, 8'd2,  8'd40, 8'h31, 1'b0, 1'b0, 2'd1, 3'd0, 3'd3, 1'b1, 5'd0},
        {8'hEF, 8'd3,  8'd7,  8'h1F, 1'b0, 1'b0, 2'd2, 3'd0, 3'd0, 1'b1, 5'd0},
        {8'h01, 8'd1,  8'd99, 8'h10, 1'b0, 1'b0, 2'd3, 3'd0, 3'd0, 1'b1, 5'd0},
        {8'h4E, 8'd16, 8'd3,  8'h12, 1'b0, 1'b1, 2'd0, 3'd7, 3'd2, 1'b1, 5'd0},
        {8'h00, 8'd4,  8'd5,  8'h12, 1'b1, 1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 5'd0},
        {8'hE0, 8'd0,  8'd0,  8'h12, 1'b0, 1'b0, 2'd0, 3'd0, 3'd7, 1'b1, 5'd0},
        {8'h00, 8'd17, 8'd9,  8'h12, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 5'd0}
    };
    localparam string TAG [8] = '{"R5", "R6", "R7", "R7", "R8", "R4", "R10", "R12"};

    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_ok) begin
                n_ok++; l_kind = frm_kind; l_ns = frm_ns; l_nr = frm_nr; l_len = frm_len;
            end
            if (frm_err) n_err++;
            if (out_valid) begin
                rx[rx_n[7:0]] = out_data;
                rx_n++;
                if (out_eop) n_eop++;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mirror(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic send_byte(input logic [7:0] x, input bit inv);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = inv ? mirror(x) : x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] addr, input logic [7:0] ctrl,
                              input logic [7:0] len, input logic [7:0] seed,
                              input bit bad, input bit inv);
        logic [7:0] sum;
        sum = addr ^ ctrl ^ len;
        send_byte(addr, inv);
        send_byte(ctrl, inv);
        send_byte(len, inv);
        for (int i = 0; i < int'(len); i++) begin
            sum = sum ^ pay(seed, i);
            send_byte(pay(seed, i), inv);
        end
        send_byte(bad ? (sum ^ 8'h5A) : sum, inv);
        repeat (25) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ok0, err0, eop0, bytes_bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!frm_ok && !frm_err && !out_valid && !out_sop && !out_eop, "R1 idle flags",
            {frm_ok, frm_err, out_valid, out_sop, out_eop}, 0);
        chk(frm_kind == 0 && frm_ns == 0 && frm_nr == 0 && frm_len == 0, "R1 fields",
            frm_len, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            logic [47:0] e;
            e = VEC[v];
            inverse_en = e[14];
            ok0 = n_ok; err0 = n_err; eop0 = n_eop; rx_n = 0;
            send_frame(e[23:16], e[47:40], e[39:32], e[31:24], e[15], e[14]);
            if (e[5]) begin
                chk(n_ok == ok0 + 1 && n_err == err0, {TAG[v], " R3 accept"}, n_ok - ok0, 1);
                chk(l_kind == e[13:12], {TAG[v], " kind"}, l_kind, e[13:12]);
                chk(l_ns == e[11:9] && l_nr == e[8:6], {TAG[v], " ns/nr"},
                    {l_ns, l_nr}, e[11:6]);
                chk(l_len == e[39:32], {TAG[v], " R3 length"}, l_len, e[39:32]);
                chk(rx_n == int'(e[39:32]), {TAG[v], " R11 replay count"}, rx_n, e[39:32]);
                bytes_bad = 0;
                for (int i = 0; i < int'(e[39:32]); i++)
                    if (rx[i] != pay(e[31:24], i)) bytes_bad++;
                chk(bytes_bad == 0, {TAG[v], " R11 replay bytes"}, bytes_bad, 0);
                chk(n_eop == eop0 + ((e[39:32] != 0) ? 1 : 0), {TAG[v], " R11 end marker"},
                    n_eop - eop0, (e[39:32] != 0) ? 1 : 0);
            end else begin
                chk(n_err == err0 + 1 && n_ok == ok0, {TAG[v], " reject pulse"},
                    n_err - err0, 1);
                chk(rx_n == 0, {TAG[v], " no replay"}, rx_n, 0);
            end
        end
        inverse_en = 1'b0;

        // R2 garbage bytes dropped, then low-nibble address accepted
        ok0 = n_ok; err0 = n_err;
        send_byte(8'h22, 1'b0);
        send_byte(8'h35, 1'b0);
        send_byte(8'h00, 1'b0);
        repeat (5) @(negedge clk);
        chk(n_ok == ok0 && n_err == err0, "R2 garbage silent", n_ok + n_err, ok0 + err0);
        rx_n = 0;
        send_frame(8'h21, 8'hA4, 8'd2, 8'd60, 1'b0, 1'b0);
        chk(n_ok == ok0 + 1 && rx_n == 2, "R2 resync accept", n_ok - ok0, 1);

        // R9 timeout drops partial frame
        ok0 = n_ok; err0 = n_err;
        send_byte(8'h12, 1'b0);
        send_byte(8'h00, 1'b0);
        send_byte(8'd3, 1'b0);
        send_byte(8'h44, 1'b0);
        @(negedge clk); timeout = 1'b1;
        @(negedge clk); timeout = 1'b0;
        rx_n = 0;
        send_frame(8'h12, 8'h02, 8'd2, 8'd77, 1'b0, 1'b0);
        chk(n_ok == ok0 + 1 && n_err == err0, "R9 fresh frame accepted", n_ok - ok0, 1);
        chk(l_len == 8'd2 && l_ns == 3'd1, "R9 fresh frame fields", l_len, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule